// File: doc/BRIEF.md
# Program/Erase Completion Poller

This block sits on the host side of a parallel flash device. It decides whether a program or erase operation that has already been launched has finished successfully or has run out of time. After a one-cycle `start` pulse it latches the expected byte, an erase flag, the address to poll and a read budget. It then reads the status byte repeatedly through a valid/ready read port. Each status byte is judged on its polling bit (bit 7) and its time-limit bit (bit 5).

If the polling bit does not yet show completion and the time-limit bit is clear, the block polls again. If the time-limit bit is set, the block does not fail at once. The polling bit may have changed in the same instant as the time-limit bit, so one more read is taken, and only a mismatch on that confirming read is reported as a failure. A host-side read budget guards against a device that never answers meaningfully.

On any failure the block can first send the read/reset command byte (0xF0) to the polled address, which returns the device to read mode. It then reports the error. Success and failure are each reported as a single-cycle pulse.

Top module: `poll_done_checker`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `error`, `err_cause`, `rd_req_valid`, `rd_rsp_ready` and `cmd_valid` are all 0. While idle, no read request and no command is presented.
- R2: For a program operation (`erase_op`=0), a status byte whose bit 7 equals bit 7 of the latched expected byte ends the operation with `done` high for exactly one cycle and no further read.
- R3: For an erase operation (`erase_op`=1), completion is a status byte with bit 7 = 1, whatever the expected byte holds.
- R4: A status byte that is not complete and has bit 5 = 0 is followed by another poll read of the same address.
- R5: A status byte that is not complete and has bit 5 = 1 is followed by exactly one confirming read. If that read is complete, the block pulses `done` and reports no error.
- R6: If the confirming read is also not complete, the block pulses `error` for one cycle with `err_cause` = 0 (device time limit). `done` and `error` are never high together.
- R7: When `reset_on_fail` was 1 at start, every failure presents one command with `cmd_data` = 0xF0 at the polled address. The command is held until accepted, and `error` pulses in the cycle after acceptance. When it was 0, no command is issued.
- R8: The read budget `max_reads`, latched at start, caps the number of poll reads that are not confirming reads. When the budget is spent without completion, no further read is issued and `error` pulses with `err_cause` = 1 (budget exhausted).
- R9: A `start` pulse while `busy` is 1 is ignored: the expected byte, address and mode of the running operation are not replaced, and no second result is produced.
- R10: Read requests follow valid/ready rules. Once `rd_req_valid` is raised, it and `rd_req_addr` stay stable until `rd_req_ready` is seen. `rd_req_addr` always equals the address latched at start, even if `poll_addr` changes afterwards. A response is taken only when `rd_rsp_valid` and `rd_rsp_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins polling; ignored while busy |
| exp_data | input | DATA_W | Byte that was programmed; bit 7 is the polling reference |
| erase_op | input | 1 | 1 selects the erase completion rule |
| poll_addr | input | ADDR_W | Address to poll |
| reset_on_fail | input | 1 | 1 issues the read/reset command on failure |
| max_reads | input | CNT_W | Read budget for the poll loop |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted by the flash side |
| rd_req_addr | output | ADDR_W | Read address |
| rd_rsp_valid | input | 1 | Status byte valid |
| rd_rsp_ready | output | 1 | Block can take a status byte |
| rd_rsp_data | input | DATA_W | Status byte |
| cmd_valid | output | 1 | Read/reset command valid |
| cmd_ready | input | 1 | Command accepted |
| cmd_addr | output | ADDR_W | Command address |
| cmd_data | output | DATA_W | Command byte (0xF0) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure pulse |
| err_cause | output | 1 | Valid with `error`: 0 device time limit, 1 budget exhausted |

## Verification
The poll loop is driven with status sequences that complete on the first read, complete only after several incomplete reads with bit 5 clear, and raise bit 5 and then either recover or stay incomplete on the confirming read. Together these separate the plain retry path from the confirm path and a true time-limit failure from a late success. Program runs with expected bit 7 set and clear, and erase runs with the expected byte cleared, show that the completion rule follows the mode and not the byte. A sequence that never completes exposes the read budget. Stalling the ready inputs, changing inputs after start and pulsing start mid-run show the handshake holding and the latched context staying put.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int POLL_BIT = 7;
  localparam int FAIL_BIT = 5;
  localparam logic [7:0] READ_RESET_CODE = 8'hF0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ1, ST_CHECK1, ST_READ2, ST_CHECK2, ST_DONE, ST_ERROR, ST_RESET_CMD
  } pdc_state_t;

  typedef enum logic {
    CAUSE_DEV_LIMIT = 1'b0,
    CAUSE_BUDGET    = 1'b1
  } pdc_cause_t;
endpackage

// File: rtl/pdc_status_eval.sv
module pdc_status_eval #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] expected,
  input  logic              erase_mode,
  output logic              complete,
  output logic              limit_hit
);
  import pdc_pkg::*;

  localparam logic [DATA_W-1:0] POLL_MASK = DATA_W'(1) << POLL_BIT;
  localparam logic [DATA_W-1:0] FAIL_MASK = DATA_W'(1) << FAIL_BIT;

  always_comb begin
    if (erase_mode) complete = |(status & POLL_MASK);
    else            complete = ((status ^ expected) & POLL_MASK) == '0;
    limit_hit = |(status & FAIL_MASK);
  end
endmodule

// File: rtl/pdc_read_budget.sv
module pdc_read_budget #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] limit_in,
  input  logic             consume,
  output logic             spent
);
  logic [CNT_W-1:0] used_q;
  logic [CNT_W-1:0] limit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q  <= '0;
      limit_q <= '0;
    end else if (load) begin
      used_q  <= '0;
      limit_q <= limit_in;
    end else if (consume && !spent) begin
      used_q <= used_q + 1'b1;
    end
  end

  assign spent = (used_q >= limit_q);
endmodule

// File: rtl/poll_done_checker.sv
module poll_done_checker #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] exp_data,
  input  logic              erase_op,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic              reset_on_fail,
  input  logic [CNT_W-1:0]  max_reads,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              err_cause
);
  import pdc_pkg::*;

  pdc_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;
  logic              erase_q;
  logic              rst_cmd_q;
  pdc_cause_t        cause_q;

  logic accept_start;
  logic sts_complete;
  logic sts_limit;
  logic budget_spent;
  logic first_read_fire;

  assign accept_start = (state_q == ST_IDLE) && start;

  pdc_status_eval #(.DATA_W(DATA_W)) u_eval (
    .status     (rd_rsp_data),
    .expected   (exp_q),
    .erase_mode (erase_q),
    .complete   (sts_complete),
    .limit_hit  (sts_limit)
  );

  pdc_read_budget #(.CNT_W(CNT_W)) u_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_start),
    .limit_in (max_reads),
    .consume  (first_read_fire),
    .spent    (budget_spent)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      exp_q     <= '0;
      erase_q   <= 1'b0;
      rst_cmd_q <= 1'b0;
      cause_q   <= CAUSE_DEV_LIMIT;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            addr_q    <= poll_addr;
            exp_q     <= exp_data;
            erase_q   <= erase_op;
            rst_cmd_q <= reset_on_fail;
            state_q   <= ST_READ1;
          end
        end
        ST_READ1: begin
          if (budget_spent) begin
            cause_q <= CAUSE_BUDGET;
            state_q <= rst_cmd_q ? ST_RESET_CMD : ST_ERROR;
          end else if (rd_req_ready) begin
            state_q <= ST_CHECK1;
          end
        end
        ST_CHECK1: begin
          if (rd_rsp_valid) begin
            if (sts_complete)   state_q <= ST_DONE;
            else if (sts_limit) state_q <= ST_READ2;
            else                state_q <= ST_READ1;
          end
        end
        ST_READ2: begin
          if (rd_req_ready) state_q <= ST_CHECK2;
        end
        ST_CHECK2: begin
          if (rd_rsp_valid) begin
            if (sts_complete) begin
              state_q <= ST_DONE;
            end else begin
              cause_q <= CAUSE_DEV_LIMIT;
              state_q <= rst_cmd_q ? ST_RESET_CMD : ST_ERROR;
            end
          end
        end
        ST_RESET_CMD: begin
          if (cmd_ready) state_q <= ST_ERROR;
        end
        ST_DONE:  state_q <= ST_IDLE;
        ST_ERROR: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_req_valid    = ((state_q == ST_READ1) && !budget_spent) || (state_q == ST_READ2);
    first_read_fire = (state_q == ST_READ1) && rd_req_valid && rd_req_ready;
    rd_rsp_ready    = (state_q == ST_CHECK1) || (state_q == ST_CHECK2);
    rd_req_addr     = addr_q;
    cmd_valid       = (state_q == ST_RESET_CMD);
    cmd_addr        = addr_q;
    cmd_data        = DATA_W'(READ_RESET_CODE);
    busy            = (state_q != ST_IDLE);
    done            = (state_q == ST_DONE);
    error           = (state_q == ST_ERROR);
    err_cause       = (state_q == ST_ERROR) ? cause_q : 1'b0;
  end
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_data,
  input logic              busy,
  input logic              done,
  input logic              error
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_data));

  // R7
  cmd_then_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> error);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);

  // R6
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !cmd_valid && !rd_rsp_ready);
endmodule

bind poll_done_checker pdc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pdc_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_rsp_ready (rd_rsp_ready),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_addr     (cmd_addr),
  .cmd_data     (cmd_data),
  .busy         (busy),
  .done         (done),
  .error        (error)
);

// File: tb/poll_done_checker_bench.sv
`timescale 1ns/1ps
module poll_done_checker_bench;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [DATA_W-1:0] exp_data = '0;
  logic              erase_op = 1'b0;
  logic [ADDR_W-1:0] poll_addr = '0;
  logic              reset_on_fail = 1'b0;
  logic [CNT_W-1:0]  max_reads = 16'd100;
  logic              rd_req_valid;
  logic              rd_req_ready = 1'b1;
  logic [ADDR_W-1:0] rd_req_addr;
  logic              rd_rsp_valid = 1'b0;
  logic              rd_rsp_ready;
  logic [DATA_W-1:0] rd_rsp_data = '0;
  logic              cmd_valid;
  logic              cmd_ready = 1'b1;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic              busy, done, error, err_cause;

  always #10 clk = ~clk;

  poll_done_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_poll_done_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_data(exp_data), .erase_op(erase_op),
    .poll_addr(poll_addr), .reset_on_fail(reset_on_fail), .max_reads(max_reads),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .busy(busy), .done(done), .error(error), .err_cause(err_cause)
  );

  int compared = 0;
  int mismatched = 0;

  // flash-side model state
  logic [7:0] seq [0:7];
  int  seq_n = 1;
  int  seq_idx = 0;
  bit  stall = 0;
  bit  phase = 0;
  bit  rsp_pending = 0;
  bit  rsp_taken = 0;

  // monitor counts
  int n_reads = 0, n_done = 0, n_err = 0, n_cmd = 0, bad_addr = 0;
  int last_cause = -1, last_cmd_data = -1, last_cmd_addr = -1;
  logic [ADDR_W-1:0] want_addr = '0;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rd_req_valid && rd_req_ready) begin
      n_reads++;
      if (rd_req_addr != want_addr) bad_addr++;
      rsp_pending = 1;
    end
    if (rd_rsp_valid && rd_rsp_ready) rsp_taken = 1;
    if (cmd_valid && cmd_ready) begin
      n_cmd++;
      last_cmd_data = int'(cmd_data);
      last_cmd_addr = int'(cmd_addr);
    end
    if (done) n_done++;
    if (error) begin
      n_err++;
      last_cause = int'(err_cause);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      phase = ~phase;
      rd_req_ready = stall ? phase : 1'b1;
      cmd_ready    = stall ? phase : 1'b1;
      if (rsp_taken) begin
        rd_rsp_valid = 1'b0;
        rsp_taken = 0;
      end
      if (rsp_pending) begin
        rsp_pending = 0;
        rd_rsp_valid = 1'b1;
        rd_rsp_data = seq[(seq_idx < seq_n) ? seq_idx : seq_n - 1];
        seq_idx++;
      end
    end
  end

  initial begin
    #(20 * 200000);
    mismatched++;
    compared++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic launch(input logic [7:0] e, input bit er, input logic [ADDR_W-1:0] a,
                        input bit rcmd, input int lim, input bit stl);
    @(negedge clk);
    n_reads = 0; n_done = 0; n_err = 0; n_cmd = 0; bad_addr = 0;
    last_cause = -1; last_cmd_data = -1; last_cmd_addr = -1;
    seq_idx = 0; stall = stl; want_addr = a;
    exp_data = e; erase_op = er; poll_addr = a; reset_on_fail = rcmd;
    max_reads = CNT_W'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp_data = ~e; erase_op = ~er; poll_addr = ~a; reset_on_fail = ~rcmd; max_reads = '0;
  endtask

  task automatic finish_wait(input string req);
    int waited = 0;
    while (n_done + n_err == 0 && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= 3000) chk({req, " completion"}, 0, 1);
    repeat (4) @(negedge clk);
    stall = 0;
  endtask

  task automatic t_reset;
    chk("R1 busy", int'(busy), 0);
    chk("R1 done/error", int'(done) + int'(error) + int'(err_cause), 0);
    chk("R1 req/rsp/cmd", int'(rd_req_valid) + int'(rd_rsp_ready) + int'(cmd_valid), 0);
  endtask

  task automatic t_prog_first;
    seq[0] = 8'h80; seq_n = 1;
    launch(8'hA5, 0, 19'h12345, 0, 100, 0);
    finish_wait("R2");
    chk("R2 reads", n_reads, 1);
    chk("R2 done cycles", n_done, 1);
    chk("R2 errors", n_err, 0);
    chk("R1 idle after", int'(busy), 0);
  endtask

  task automatic t_prog_retry;
    seq[0] = 8'h80; seq[1] = 8'h80; seq[2] = 8'h00; seq_n = 3;
    launch(8'h3C, 0, 19'h00777, 0, 100, 0);
    finish_wait("R4");
    chk("R4 reads", n_reads, 3);
    chk("R4 done", n_done, 1);
    chk("R4 addr", bad_addr, 0);
  endtask

  task automatic t_erase;
    seq[0] = 8'h00; seq[1] = 8'h00; seq[2] = 8'h80; seq_n = 3;
    launch(8'h00, 1, 19'h40000, 0, 100, 0);
    finish_wait("R3");
    chk("R3 reads", n_reads, 3);
    chk("R3 done", n_done, 1);
    chk("R3 errors", n_err, 0);
  endtask

  task automatic t_confirm_ok;
    seq[0] = 8'h20; seq[1] = 8'hA0; seq_n = 2;
    launch(8'h80, 0, 19'h00010, 1, 100, 0);
    finish_wait("R5");
    chk("R5 reads", n_reads, 2);
    chk("R5 done", n_done, 1);
    chk("R5 errors", n_err, 0);
    chk("R5 cmds", n_cmd, 0);
  endtask

  task automatic t_fail_nocmd;
    seq[0] = 8'h20; seq[1] = 8'h20; seq_n = 2;
    launch(8'h80, 0, 19'h00020, 0, 100, 0);
    finish_wait("R6");
    chk("R6 reads", n_reads, 2);
    chk("R6 error cycles", n_err, 1);
    chk("R6 cause", last_cause, 0);
    chk("R6 done", n_done, 0);
    chk("R7 no cmd when disabled", n_cmd, 0);
  endtask

  task automatic t_fail_cmd;
    seq[0] = 8'h60; seq[1] = 8'h60; seq_n = 2;
    launch(8'hFF, 0, 19'h5A5A5, 1, 100, 1);
    finish_wait("R7");
    chk("R7 cmds", n_cmd, 1);
    chk("R7 cmd data", last_cmd_data, 32'hF0);
    chk("R7 cmd addr", last_cmd_addr, 32'h5A5A5);
    chk("R7 error", n_err, 1);
    chk("R6 cause", last_cause, 0);
  endtask

  task automatic t_budget;
    seq[0] = 8'h00; seq_n = 1;
    launch(8'h80, 0, 19'h00300, 0, 4, 0);
    finish_wait("R8");
    chk("R8 reads", n_reads, 4);
    chk("R8 error", n_err, 1);
    chk("R8 cause", last_cause, 1);
    seq[0] = 8'h00; seq_n = 1;
    launch(8'h80, 0, 19'h00301, 1, 0, 0);
    finish_wait("R8 zero");
    chk("R8 zero-budget reads", n_reads, 0);
    chk("R8 zero-budget cmd", n_cmd, 1);
    chk("R8 zero-budget cause", last_cause, 1);
  endtask

  task automatic t_start_busy;
    seq[0] = 8'h00; seq[1] = 8'h00; seq[2] = 8'h80; seq_n = 3;
    launch(8'h80, 0, 19'h01111, 0, 100, 1);
    repeat (3) @(negedge clk);
    exp_data = 8'h00; erase_op = 0; poll_addr = 19'h02222; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_wait("R9");
    chk("R9 reads", n_reads, 3);
    chk("R9 done", n_done, 1);
    chk("R9 addr kept", bad_addr, 0);
    repeat (6) @(negedge clk);
    chk("R9 no restart", n_reads + int'(busy), 3);
  endtask

  task automatic t_backpressure;
    seq[0] = 8'h00; seq[1] = 8'h00; seq[2] = 8'h00; seq[3] = 8'h80; seq_n = 4;
    launch(8'hC3, 0, 19'h6ABCD, 0, 100, 1);
    finish_wait("R10");
    chk("R10 reads", n_reads, 4);
    chk("R10 latched addr", bad_addr, 0);
    chk("R10 done", n_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_prog_first();
    t_prog_retry();
    t_erase();
    t_confirm_ok();
    t_fail_nocmd();
    t_fail_cmd();
    t_budget();
    t_start_busy();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule